// File: doc/BRIEF.md
# Power Monitor Averaging Accumulator

This block sits between a 12-bit measurement front end and the register file of a supply monitor. It decides when a conversion runs, gathers a chosen number of voltage and load-current samples (and, when asked, auxiliary samples) and turns them into averaged readings. From those readings it forms a power product and adds it to a running energy total. A conversion starts on a one-cycle command, on a debounced rising level of an external convert pin, or again and again while continuous mode is held.

The front end watches `convActive` and `chanSel` to know when a sample is wanted and which channel it should carry. It then presents the sample with `smpValid`. The averaged readings, the power product and `dataReady` all change on the same edge, so a reader never sees half of an average. The energy total and its interval count are read by pulsing `accRead`. That pulse copies both values to the outputs and restarts the interval on the same edge, so no conversion is lost between two reads.

Top module: `pmon_avg_acc`

## Requirements
- R1: While reset is held, and after it is released, every reading, `powerOut`, `accSum`, `accCount`, `dataReady`, `convActive` and `chanSel` are zero.
- R2: A `cmdStart` pulse while idle makes `convActive` 1 from the next clock edge. A `smpValid` strobe while idle has no effect on any later result.
- R3: While `contMode` is 1, a new conversion starts on the edge that publishes the previous result. When `contMode` is 0 at that edge, the block stays idle.
- R4: `convPin` starts a conversion only after it has been sampled high on GLITCH_CYC consecutive edges. A shorter high pulse starts nothing.
- R5: `avgSel` encoding: 00 averages 1 sample, 01 averages 16 samples, 10 and 11 average 128 samples. Each reading is floor(sum of samples / count).
- R6: With `auxEn` = 1, each sample takes two strobes. The first carries voltage and current while `chanSel` = 0, and the second carries the auxiliary value while `chanSel` = 1. With `auxEn` = 0, `avgAux` keeps its previous value.
- R7: `avgSel` and `auxEn` are taken at the start edge. Changing them during a conversion has no effect on it.
- R8: All readings, `powerOut` and a one-cycle `dataReady` pulse update on the edge after the final strobe. Between publishes the readings hold steady.
- R9: `powerOut` equals `avgVolt` × `avgCurr` as a 24-bit product.
- R10: Each publish adds the new `powerOut` to the live energy total and adds 1 to the live interval count.
- R11: An `accRead` pulse copies the live total and count to `accSum` and `accCount` and clears both live values on the same edge. A publish on that same edge is included in the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | One-cycle conversion command |
| contMode | input | 1 | Continuous conversion enable |
| convPin | input | 1 | External convert request, debounced inside |
| avgSel | input | 2 | Averaging depth select |
| auxEn | input | 1 | Add the auxiliary channel to the sequence |
| smpValid | input | 1 | Sample strobe from the front end |
| smpVolt | input | 12 | Voltage sample |
| smpCurr | input | 12 | Current sample |
| smpAux | input | 12 | Auxiliary sample |
| accRead | input | 1 | Copy and clear the energy total |
| convActive | output | 1 | Conversion in progress |
| chanSel | output | 1 | 0: voltage/current strobe wanted, 1: auxiliary strobe wanted |
| avgVolt | output | 12 | Averaged voltage |
| avgCurr | output | 12 | Averaged current |
| avgAux | output | 12 | Averaged auxiliary input |
| powerOut | output | 24 | Voltage × current product |
| accSum | output | 48 | Energy total captured at the last read |
| accCount | output | 16 | Number of publishes in that total |
| dataReady | output | 1 | One-cycle pulse when results update |

## Verification
The bench keeps the 12-bit data, 48-bit total and 16-bit count defaults, but builds the block with GLITCH_CYC = 4. This lets a pulse one edge too short and a pulse of exactly the filter length both be tried in a few cycles. With the default depths, the 128-sample runs with and without the auxiliary strobe show the full 7-bit shift and the widest sums, at sample values near the top of the 12-bit range. A read on the same edge as a publish is also driven.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int MAX_SHIFT = 7;

  typedef enum logic {ST_IDLE, ST_RUN} pmonState_t;

  typedef struct packed {
    logic       clrSum;
    logic       addVI;
    logic       addAux;
    logic       finish;
    logic       publish;
    logic       auxOn;
    logic [2:0] shAmt;
  } pmonStrobe_t;
endpackage

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int GLITCH_CYC = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        contMode,
  input  logic        convPin,
  input  logic [1:0]  avgSel,
  input  logic        auxEn,
  input  logic        smpValid,
  output pmonStrobe_t stb,
  output logic        convActive,
  output logic        chanSel
);
  localparam int GL_W  = $clog2(GLITCH_CYC + 1);
  localparam int IDX_W = MAX_SHIFT;

  logic [GL_W-1:0]  glCnt;
  logic             pinTrig;
  pmonState_t       state;
  logic [IDX_W-1:0] smpIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             auxPhase;
  logic [1:0]       selQ;
  logic             auxQ;
  logic             pubQ;
  logic             startReq;
  logic             take;
  logic             sampleDone;
  logic [2:0]       shAmt;

  // Convert pin debounce: counts consecutive high samples, saturating.
  assign pinTrig = convPin && (glCnt == GL_W'(GLITCH_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            glCnt <= '0;
    else if (!convPin)                    glCnt <= '0;
    else if (glCnt != GL_W'(GLITCH_CYC))  glCnt <= glCnt + 1'b1;
  end

  always_comb begin
    unique case (selQ)
      2'b00:   begin lastIdx = IDX_W'(0);   shAmt = 3'd0; end
      2'b01:   begin lastIdx = IDX_W'(15);  shAmt = 3'd4; end
      default: begin lastIdx = IDX_W'(127); shAmt = 3'd7; end
    endcase
  end

  assign startReq   = (state == ST_IDLE) && (cmdStart || contMode || pinTrig);
  assign take       = (state == ST_RUN) && smpValid;
  assign sampleDone = take && (auxPhase || !auxQ);

  always_comb begin
    stb.clrSum  = startReq;
    stb.addVI   = take && !auxPhase;
    stb.addAux  = take && auxPhase;
    stb.finish  = sampleDone && (smpIdx == lastIdx);
    stb.publish = pubQ;
    stb.auxOn   = auxQ;
    stb.shAmt   = shAmt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      smpIdx   <= '0;
      auxPhase <= 1'b0;
      selQ     <= 2'b00;
      auxQ     <= 1'b0;
      pubQ     <= 1'b0;
    end else begin
      pubQ <= stb.finish;
      if (startReq) begin
        state    <= ST_RUN;
        smpIdx   <= '0;
        auxPhase <= 1'b0;
        selQ     <= avgSel;
        auxQ     <= auxEn;
      end else if (state == ST_RUN) begin
        if (stb.addVI && auxQ) auxPhase <= 1'b1;
        if (sampleDone) begin
          auxPhase <= 1'b0;
          smpIdx   <= smpIdx + 1'b1;
        end
        if (stb.finish) state <= ST_IDLE;
      end
    end
  end

  assign convActive = (state == ST_RUN);
  assign chanSel    = auxPhase;

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!convActive && cmdStart) |=> convActive); // R2
  AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (stb.publish && contMode) |=> convActive); // R3
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    convActive |-> (smpIdx <= lastIdx)); // R5
  AST_AUX_PHASE_ONLY_WITH_AUX: assert property (@(posedge clk) disable iff (!rstN)
    chanSel |-> (auxQ && convActive)); // R6
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (convActive && $past(convActive)) |-> ($stable(selQ) && $stable(auxQ))); // R7
endmodule

// File: rtl/pmon_dpath.sv
module pmon_dpath
  import pmon_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 48,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  pmonStrobe_t         stb,
  input  logic [DATA_W-1:0]   smpVolt,
  input  logic [DATA_W-1:0]   smpCurr,
  input  logic [DATA_W-1:0]   smpAux,
  input  logic                accRead,
  output logic [DATA_W-1:0]   avgVolt,
  output logic [DATA_W-1:0]   avgCurr,
  output logic [DATA_W-1:0]   avgAux,
  output logic [2*DATA_W-1:0] powerOut,
  output logic [ACC_W-1:0]    accSum,
  output logic [CNT_W-1:0]    accCount,
  output logic                dataReady
);
  localparam int SUM_W = DATA_W + MAX_SHIFT;
  localparam int PWR_W = 2 * DATA_W;
  localparam int NCH   = 3;

  logic [DATA_W-1:0] chIn   [NCH];
  logic              chAdd  [NCH];
  logic              chLive [NCH];

  always_comb begin
    chIn[0]   = smpVolt;
    chIn[1]   = smpCurr;
    chIn[2]   = smpAux;
    chAdd[0]  = stb.addVI;
    chAdd[1]  = stb.addVI;
    chAdd[2]  = stb.addAux;
    chLive[0] = 1'b1;
    chLive[1] = 1'b1;
    chLive[2] = stb.auxOn;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SUM_W-1:0]  chSum;
    logic [SUM_W-1:0]  chNext;
    logic [SUM_W-1:0]  chFinal;
    logic [DATA_W-1:0] avgQ;

    assign chNext  = chSum + SUM_W'(chIn[c]);
    assign chFinal = chAdd[c] ? chNext : chSum;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chSum <= '0;
        avgQ  <= '0;
      end else begin
        if (stb.clrSum || stb.finish) chSum <= '0;
        else if (chAdd[c])            chSum <= chNext;
        if (stb.finish && chLive[c])  avgQ  <= DATA_W'(chFinal >> stb.shAmt);
      end
    end
  end

  logic [PWR_W-1:0] pwrNext;
  logic [ACC_W-1:0] accLive;
  logic [ACC_W-1:0] accAdd;
  logic [CNT_W-1:0] cntLive;

  assign pwrNext = PWR_W'(g_ch[0].avgQ) * PWR_W'(g_ch[1].avgQ);
  assign accAdd  = accLive + ACC_W'(pwrNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      avgVolt   <= '0;
      avgCurr   <= '0;
      avgAux    <= '0;
      powerOut  <= '0;
      dataReady <= 1'b0;
      accLive   <= '0;
      cntLive   <= '0;
      accSum    <= '0;
      accCount  <= '0;
    end else begin
      dataReady <= stb.publish;
      if (stb.publish) begin
        avgVolt  <= g_ch[0].avgQ;
        avgCurr  <= g_ch[1].avgQ;
        avgAux   <= g_ch[2].avgQ;
        powerOut <= pwrNext;
      end
      if (accRead) begin
        accSum   <= stb.publish ? accAdd : accLive;
        accCount <= stb.publish ? cntLive + 1'b1 : cntLive;
        accLive  <= '0;
        cntLive  <= '0;
      end else if (stb.publish) begin
        accLive <= accAdd;
        cntLive <= cntLive + 1'b1;
      end
    end
  end

  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> !dataReady); // R8
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !dataReady |-> ($stable(avgVolt) && $stable(avgCurr) && $stable(avgAux))); // R8
  AST_POWER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    powerOut == PWR_W'(avgVolt) * PWR_W'(avgCurr)); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.publish && !accRead) |=> (cntLive == $past(cntLive) + 1'b1)); // R10
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    accRead |=> (cntLive == '0 && accLive == '0)); // R11
endmodule

// File: rtl/pmon_avg_acc.sv
module pmon_avg_acc
  import pmon_pkg::*;
#(
  parameter int GLITCH_CYC = 50,
  parameter int DATA_W     = 12,
  parameter int ACC_W      = 48,
  parameter int CNT_W      = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdStart,
  input  logic                contMode,
  input  logic                convPin,
  input  logic [1:0]          avgSel,
  input  logic                auxEn,
  input  logic                smpValid,
  input  logic [DATA_W-1:0]   smpVolt,
  input  logic [DATA_W-1:0]   smpCurr,
  input  logic [DATA_W-1:0]   smpAux,
  input  logic                accRead,
  output logic                convActive,
  output logic                chanSel,
  output logic [DATA_W-1:0]   avgVolt,
  output logic [DATA_W-1:0]   avgCurr,
  output logic [DATA_W-1:0]   avgAux,
  output logic [2*DATA_W-1:0] powerOut,
  output logic [ACC_W-1:0]    accSum,
  output logic [CNT_W-1:0]    accCount,
  output logic                dataReady
);
  pmonStrobe_t stb;

  pmon_ctrl #(.GLITCH_CYC(GLITCH_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .contMode(contMode),
    .convPin(convPin), .avgSel(avgSel), .auxEn(auxEn), .smpValid(smpValid),
    .stb(stb), .convActive(convActive), .chanSel(chanSel)
  );

  pmon_dpath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .smpVolt(smpVolt), .smpCurr(smpCurr),
    .smpAux(smpAux), .accRead(accRead), .avgVolt(avgVolt), .avgCurr(avgCurr),
    .avgAux(avgAux), .powerOut(powerOut), .accSum(accSum), .accCount(accCount),
    .dataReady(dataReady)
  );
endmodule

// File: tb/sim_pmon_avg_acc.sv
module sim_pmon_avg_acc;
  localparam int CLK_PERIOD = 10;
  localparam int GL         = 4;

  typedef struct packed {
    logic [1:0]  sel;
    logic        aux;
    logic [11:0] vb;
    logic [11:0] ib;
    logic [11:0] ab;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 12'd100,  12'd200,  12'd50},
    '{2'd1, 1'b0, 12'd1000, 12'd300,  12'd7},
    '{2'd2, 1'b0, 12'd3000, 12'd1000, 12'd0},
    '{2'd1, 1'b1, 12'd55,   12'd66,   12'd77},
    '{2'd3, 1'b1, 12'd3968, 12'd3714, 12'd3841},
    '{2'd0, 1'b1, 12'd4095, 12'd4095, 12'd4095}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, contMode = 1'b0, convPin = 1'b0;
  logic [1:0] avgSel = 2'd0;
  logic auxEn = 1'b0, smpValid = 1'b0, accRead = 1'b0;
  logic [11:0] smpVolt = '0, smpCurr = '0, smpAux = '0;
  logic convActive, chanSel, dataReady;
  logic [11:0] avgVolt, avgCurr, avgAux;
  logic [23:0] powerOut;
  logic [47:0] accSum;
  logic [15:0] accCount;

  int checks = 0;
  int errors = 0;
  longint expAcc = 0;
  longint expCnt = 0;
  longint expAuxAvg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmon_avg_acc #(.GLITCH_CYC(GL)) u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .contMode(contMode),
    .convPin(convPin), .avgSel(avgSel), .auxEn(auxEn), .smpValid(smpValid),
    .smpVolt(smpVolt), .smpCurr(smpCurr), .smpAux(smpAux), .accRead(accRead),
    .convActive(convActive), .chanSel(chanSel), .avgVolt(avgVolt),
    .avgCurr(avgCurr), .avgAux(avgAux), .powerOut(powerOut), .accSum(accSum),
    .accCount(accCount), .dataReady(dataReady)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one commanded conversion; every sample set is derived from the bases.
  task automatic runConv(input logic [1:0] sel, input logic aux,
                         input int vb, input int ib, input int ab,
                         input logic readAtPub);
    int n;
    longint sv, si, sa, ev, ei, ea, pw;
    n  = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 16 : 128;
    sv = 0; si = 0; sa = 0;
    cmdStart = 1'b1; avgSel = sel; auxEn = aux;
    cyc();
    cmdStart = 1'b0;
    chk("R2 convActive after command", convActive, 1);
    avgSel = ~sel; auxEn = ~aux;  // R7: changes after start must be ignored
    for (int k = 0; k < n; k++) begin
      smpVolt = 12'(vb + k); smpCurr = 12'(ib + 3*k); smpValid = 1'b1;
      sv += vb + k; si += ib + 3*k;
      if (k == 0 && aux) chk("R6 chanSel voltage/current phase", chanSel, 0);
      cyc();
      if (aux) begin
        if (k == 0) chk("R6 chanSel auxiliary phase", chanSel, 1);
        smpAux = 12'(ab + 2*k);
        sa += ab + 2*k;
        cyc();
      end
    end
    smpValid = 1'b0;
    accRead = readAtPub;
    chk("R8 no ready before publish", dataReady, 0);
    cyc();
    accRead = 1'b0;
    ev = sv / n; ei = si / n;
    if (aux) expAuxAvg = sa / n;
    pw = ev * ei;
    chk("R8 dataReady pulse", dataReady, 1);
    chk("R5 averaged voltage", avgVolt, ev);
    chk("R5 averaged current", avgCurr, ei);
    chk("R6 auxiliary reading", avgAux, expAuxAvg);
    chk("R9 power product", powerOut, pw);
    expAcc += pw; expCnt += 1;
    if (readAtPub) begin
      chk("R11 coincident read sum", accSum, expAcc);
      chk("R11 coincident read count", accCount, expCnt);
      expAcc = 0; expCnt = 0;
    end
    cyc();
    chk("R8 dataReady single cycle", dataReady, 0);
    chk("R8 readings held", avgVolt, ev);
  endtask

  task automatic readAcc(input string tag);
    accRead = 1'b1;
    cyc();
    accRead = 1'b0;
    chk({tag, " sum"}, accSum, expAcc);
    chk({tag, " count"}, accCount, expCnt);
    expAcc = 0; expCnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 convActive in reset", convActive, 0);
    chk("R1 avgVolt in reset", avgVolt, 0);
    rstN = 1'b1;
    cyc();
    chk("R1 dataReady after reset", dataReady, 0);
    chk("R1 powerOut after reset", powerOut, 0);
    chk("R1 accCount after reset", accCount, 0);
    chk("R1 chanSel after reset", chanSel, 0);

    // R2: strobes while idle are ignored
    smpVolt = 12'd999; smpCurr = 12'd999; smpValid = 1'b1;
    cyc(); cyc();
    smpValid = 1'b0;
    chk("R2 idle strobes start nothing", convActive, 0);
    runConv(2'd0, 1'b0, 10, 20, 0, 1'b0);

    // Vector table: R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NVEC; v++)
      runConv(VECS[v].sel, VECS[v].aux, int'(VECS[v].vb), int'(VECS[v].ib),
              int'(VECS[v].ab), 1'b0);

    // R10 then R11: read collects everything, second read is empty
    readAcc("R10 accumulated");
    readAcc("R11 cleared after read");

    // R4: short convert pulse ignored, full-length pulse starts
    avgSel = 2'd0; auxEn = 1'b0;
    convPin = 1'b1;
    repeat (GL - 1) cyc();
    convPin = 1'b0;
    cyc();
    chk("R4 short pulse ignored", convActive, 0);
    convPin = 1'b1;
    repeat (GL - 1) cyc();
    chk("R4 not yet started", convActive, 0);
    cyc();
    convPin = 1'b0;
    chk("R4 filtered pin starts conversion", convActive, 1);
    smpVolt = 12'd40; smpCurr = 12'd50; smpValid = 1'b1;
    cyc();
    smpValid = 1'b0;
    cyc();
    chk("R4 pin-started result", avgVolt, 40);
    expAcc += 2000; expCnt += 1;

    // R3: continuous mode restarts on the publish edge
    contMode = 1'b1;
    cyc();
    smpVolt = 12'd7; smpCurr = 12'd9; smpValid = 1'b1;
    cyc();
    smpValid = 1'b0;
    cyc();
    chk("R3 restart on publish edge", convActive, 1);
    chk("R3 first result", avgVolt, 7);
    contMode = 1'b0;
    smpVolt = 12'd11; smpCurr = 12'd13; smpValid = 1'b1;
    cyc();
    smpValid = 1'b0;
    cyc();
    chk("R3 second result", avgCurr, 13);
    chk("R3 stops when mode cleared", convActive, 0);
    expAcc += 63 + 143; expCnt += 2;
    readAcc("R10 after pin and continuous runs");

    // R11: read on the same edge as a publish
    runConv(2'd1, 1'b0, 500, 600, 0, 1'b1);
    readAcc("R11 after coincident read");

    finishSim();
  end
endmodule